// File: doc/BRIEF.md
# Shared-State Tree Pseudo-LRU Replacement

This block chooses replacement ways for a set-associative cache using a tree pseudo-LRU policy. All sets keep their tree bits in one small state memory. The memory has an asynchronous read port and a synchronous write port, so it maps onto distributed LUT memory. One combinational function serves every set. It gives the victim way for a state word, and it gives the new state word after a given way is used.

The cache drives the tag-match outcome for one set in its lookup cycle: the set index, a hit flag and the hit way. The block registers that outcome. In the following cycle it reads the set's state word. A hit writes the refreshed word back at the end of that cycle. If the lookup missed and the cache raises `miss_start` in that cycle, the block latches the victim way for the refill instead. After reset the block clears the state memory one set per cycle and ignores lookups until the sweep is over.

Top module: `plru_repl`

## Requirements
- R1: While `rst_n` is low, `ready` is 0. After `rst_n` goes high, `ready` stays 0 for exactly NUM_SETS rising edges, during which every set's state is cleared. It then stays 1 until the next reset.
- R2: A lookup presented while `ready` is 0 is ignored, together with any `miss_start`. It updates no state and it raises no `victim_valid`.
- R3: State encoding: each set holds NUM_WAYS-1 tree bits, and node n has children 2n+1 and 2n+2. A bit value of 0 sends the victim walk to the lower-numbered half, and 1 sends it to the upper half. The walk starts at the root, and the bit at each level gives the next bit of the way number, MSB first. A cleared set therefore has victim way 0.
- R4: A lookup with `lk_hit`=1 for way w sets every node on w's path so that it points away from w. The new word is written at the end of the cycle after the lookup cycle, and bits off the path keep their values.
- R5: When `miss_start` is 1 in the cycle after an accepted missing lookup, the victim for that set is latched. `victim_valid` is then 1 for exactly the next cycle, with `victim_way` holding that victim.
- R6: A miss without `miss_start` writes no state and raises no `victim_valid`. A `miss_start` that does not follow an accepted missing lookup by one cycle is ignored.
- R7: A hit's state update is visible to a lookup of the same set presented in the very next cycle.
- R8: Accesses to one set never change the victim of another set.
- R9: Right after a hit to way w in a set, the victim of that set is not w.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Tag-match result valid this cycle |
| lk_set | input | SET_W | Set index of the lookup |
| lk_hit | input | 1 | Lookup hit |
| lk_way | input | WAY_W | Way that hit |
| miss_start | input | 1 | Miss handling starts (cycle after a missing lookup) |
| ready | output | 1 | Clear sweep finished, lookups accepted |
| victim_valid | output | 1 | One-cycle strobe, victim_way valid |
| victim_way | output | WAY_W | Chosen way for the refill |

## Verification
On every cycle the assertions check the framing rules. No lookup is taken while the sweep runs. `ready` never falls once it is high. The state memory is written only by the sweep or by an accepted hit. A victim strobe comes only one cycle after an accepted miss with `miss_start`. The bench scenarios cover the tree arithmetic: victims after sequences of hits, back-to-back hits and probes on the same set, isolation between sets, and clearing after a second reset. It checks each of these against a reference model of the tree.

// File: rtl/plru_pkg.sv
// Package: shared helpers for the tree pseudo-LRU block.
// Assumes heap numbering of tree nodes (root 0, children 2n+1, 2n+2).
package plru_pkg;

    // Child node index reached from node n when taking direction dir.
    function automatic int tree_child(input int n, input logic dir);
        return 2 * n + 1 + int'(dir);
    endfunction

endpackage

// File: rtl/plru_fn.sv
// Module: plru_fn
// Purely combinational tree pseudo-LRU function, shared by all sets.
// Gives the victim way of a state word, and the state word after way
// acc_way has been used. Assumes NUM_WAYS is a power of two, >= 2.
module plru_fn #(
    parameter int NUM_WAYS = 4,
    localparam int WAY_W  = $clog2(NUM_WAYS),
    localparam int TREE_W = NUM_WAYS - 1
) (
    input  logic [TREE_W-1:0] cur_state,
    input  logic [WAY_W-1:0]  acc_way,
    output logic [WAY_W-1:0]  victim,
    output logic [TREE_W-1:0] next_state
);
    import plru_pkg::*;

    // Victim: walk from the root, each bit selects the half to evict.
    always_comb begin
        int node;
        node   = 0;
        victim = '0;
        for (int lvl = 0; lvl < WAY_W; lvl++) begin
            victim[WAY_W-1-lvl] = cur_state[node];
            node = tree_child(node, cur_state[node]);
        end
    end

    // Update: point every node on the accessed way's path away from it.
    always_comb begin
        int   node;
        logic dir;
        node       = 0;
        next_state = cur_state;
        for (int lvl = 0; lvl < WAY_W; lvl++) begin
            dir              = acc_way[WAY_W-1-lvl];
            next_state[node] = ~dir;
            node             = tree_child(node, dir);
        end
    end

endmodule

// File: rtl/plru_state_ram.sv
// Module: plru_state_ram
// Per-set state memory: asynchronous read, synchronous write, no reset
// (contents are cleared by the sweep). Sized to map onto LUT memory.
module plru_state_ram #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 3,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    // Write port: one entry per cycle on we.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Read port: combinational.
    assign rdata = mem[raddr];

    AST_WADDR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> (int'(waddr) < DEPTH)); // R4

endmodule

// File: rtl/plru_sweep.sv
// Module: plru_sweep
// After reset, steps through every set index, one per cycle, and
// flags busy until the last one has been issued. Assumes DEPTH >= 2.
module plru_sweep #(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic          busy,
    output logic [AW-1:0] idx
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    // Sweep counter: runs once from 0 to LAST after each reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b1;
            idx  <= '0;
        end else if (busy) begin
            idx <= idx + 1'b1;
            if (idx == LAST) busy <= 1'b0;
        end
    end

    AST_SWEEP_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> !busy); // R1

endmodule

// File: rtl/plru_repl.sv
// Module: plru_repl (top)
// Tree pseudo-LRU replacement with state for all sets in one memory.
// Lookup-cycle tag-match results are registered. In the next cycle the
// set's state is read, a hit writes the refreshed state, and a miss with
// miss_start latches the victim. Assumes NUM_WAYS a power of two >= 2
// and NUM_SETS >= 2.
module plru_repl #(
    parameter int NUM_SETS = 16,
    parameter int NUM_WAYS = 4,
    localparam int SET_W  = $clog2(NUM_SETS),
    localparam int WAY_W  = $clog2(NUM_WAYS),
    localparam int TREE_W = NUM_WAYS - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_valid,
    input  logic [SET_W-1:0] lk_set,
    input  logic             lk_hit,
    input  logic [WAY_W-1:0] lk_way,
    input  logic             miss_start,
    output logic             ready,
    output logic             victim_valid,
    output logic [WAY_W-1:0] victim_way
);
    logic              sweep_busy;
    logic [SET_W-1:0]  sweep_idx;
    logic              s1_valid, s1_hit;
    logic [SET_W-1:0]  s1_set;
    logic [WAY_W-1:0]  s1_way;
    logic [TREE_W-1:0] rd_state, upd_state, wr_state;
    logic [WAY_W-1:0]  fn_victim;
    logic              ram_we, take_victim;
    logic [SET_W-1:0]  ram_waddr;

    plru_sweep #(.DEPTH(NUM_SETS)) sweep_i (
        .clk  (clk),
        .rst_n(rst_n),
        .busy (sweep_busy),
        .idx  (sweep_idx)
    );

    assign ready = ~sweep_busy;

    // Stage register: hold the tag-match result for the state cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_hit   <= 1'b0;
            s1_set   <= '0;
            s1_way   <= '0;
        end else begin
            s1_valid <= lk_valid & ready;
            s1_hit   <= lk_hit;
            s1_set   <= lk_set;
            s1_way   <= lk_way;
        end
    end

    plru_state_ram #(.DEPTH(NUM_SETS), .WIDTH(TREE_W)) ram_i (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (ram_we),
        .waddr(ram_waddr),
        .wdata(wr_state),
        .raddr(s1_set),
        .rdata(rd_state)
    );

    plru_fn #(.NUM_WAYS(NUM_WAYS)) fn_i (
        .cur_state (rd_state),
        .acc_way   (s1_way),
        .victim    (fn_victim),
        .next_state(upd_state)
    );

    // Write port select: sweep clears, otherwise a hit stores its update.
    always_comb begin
        if (sweep_busy) begin
            ram_we    = 1'b1;
            ram_waddr = sweep_idx;
            wr_state  = '0;
        end else begin
            ram_we    = s1_valid & s1_hit;
            ram_waddr = s1_set;
            wr_state  = upd_state;
        end
    end

    assign take_victim = s1_valid & ~s1_hit & miss_start;

    // Victim register: latch the chosen way when miss handling begins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            victim_valid <= 1'b0;
            victim_way   <= '0;
        end else begin
            victim_valid <= take_victim;
            if (take_victim) victim_way <= fn_victim;
        end
    end

    AST_NO_LOOKUP_IN_SWEEP: assert property (@(posedge clk) disable iff (!rst_n)
        sweep_busy |=> !s1_valid); // R2
    AST_READY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready); // R1
    AST_WRITE_ONLY_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && ram_we) |-> (s1_valid && s1_hit)); // R6
    AST_VICTIM_FROM_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        victim_valid |-> $past(s1_valid && !s1_hit && miss_start)); // R5
    AST_VICTIM_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && !s1_hit && miss_start) |=> victim_valid); // R5

endmodule

// File: tb/plru_repl_tb_top.sv
module plru_repl_tb_top;
    localparam int NUM_SETS = 16;
    localparam int NUM_WAYS = 4;
    localparam int SET_W  = $clog2(NUM_SETS);
    localparam int WAY_W  = $clog2(NUM_WAYS);
    localparam int TREE_W = NUM_WAYS - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lk_valid = 1'b0;
    logic [SET_W-1:0] lk_set = '0;
    logic lk_hit = 1'b0;
    logic [WAY_W-1:0] lk_way = '0;
    logic miss_start = 1'b0;
    logic ready, victim_valid;
    logic [WAY_W-1:0] victim_way;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;
    logic [TREE_W-1:0] mdl [NUM_SETS];

    always #5 clk = ~clk;

    plru_repl #(.NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS)) dut_i (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_set(lk_set),
        .lk_hit(lk_hit), .lk_way(lk_way), .miss_start(miss_start),
        .ready(ready), .victim_valid(victim_valid), .victim_way(victim_way)
    );

    // Reference: node on level l of way w's path is (2^l - 1) + (w >> (WAY_W-l)).
    function automatic logic [TREE_W-1:0] ref_update(input logic [TREE_W-1:0] st, input int w);
        logic [TREE_W-1:0] r = st;
        for (int l = 0; l < WAY_W; l++) begin
            int node = (1 << l) - 1 + (w >> (WAY_W - l));
            r[node] = ~logic'((w >> (WAY_W - 1 - l)) & 1);
        end
        return r;
    endfunction

    function automatic int ref_victim(input logic [TREE_W-1:0] st);
        int v = 0;
        for (int l = 0; l < WAY_W; l++) begin
            v = (v << 1) | int'(st[(1 << l) - 1 + v]);
        end
        return v;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        lk_valid = 0; lk_hit = 0; miss_start = 0;
    endtask

    // Reset and count edges until ready; optionally drive lookups during sweep.
    task automatic do_reset(input bit drive_sweep);
        int n = 0;
        bit strobe = 0;
        @(negedge clk);
        rst_n = 0; idle_inputs();
        repeat (3) @(negedge clk);
        check("R1 ready low in reset", int'(ready), 0);
        rst_n = 1;
        if (drive_sweep) begin
            lk_valid = 1; lk_hit = 1; lk_set = 3; lk_way = 0; miss_start = 1;
        end
        while (!ready && n < NUM_SETS + 10) begin
            @(negedge clk);
            n++;
            if (victim_valid) strobe = 1;
        end
        idle_inputs();
        check("R1 sweep length", n, NUM_SETS);
        if (drive_sweep) check("R2 no victim during sweep", int'(strobe), 0);
        @(negedge clk);
        check("R2 no victim after sweep", int'(victim_valid), 0);
        for (int s = 0; s < NUM_SETS; s++) mdl[s] = '0;
    endtask

    task automatic do_hit(input int s, input int w);
        lk_valid = 1; lk_hit = 1; lk_set = SET_W'(s); lk_way = WAY_W'(w);
        @(negedge clk);
        idle_inputs();
        mdl[s] = ref_update(mdl[s], w);
    endtask

    // Missing lookup followed by miss_start; checks the victim strobe.
    task automatic probe(input int s, input string req);
        lk_valid = 1; lk_hit = 0; lk_set = SET_W'(s);
        @(negedge clk);
        idle_inputs(); miss_start = 1;
        @(negedge clk);
        miss_start = 0;
        check({req, " victim_valid"}, int'(victim_valid), 1);
        check(req, int'(victim_way), ref_victim(mdl[s]));
        @(negedge clk);
        check("R5 strobe one cycle", int'(victim_valid), 0);
    endtask

    initial begin
        int sd;
        sd = $urandom(1234);
        do_reset(1'b0);

        // R3: cleared set evicts way 0
        probe(0, "R3 cleared victim");
        // R4: hit way 0 in set 5 -> victim way 2
        do_hit(5, 0);
        check("R4 model victim", ref_victim(mdl[5]), 2);
        probe(5, "R4 after hit way0");
        // R8: neighbour untouched
        probe(6, "R8 other set");
        // R4: hit way 2 keeps node 1 -> victim way 1
        do_hit(5, 2);
        probe(5, "R4 off-path bits kept");
        // R7: hit then immediate missing lookup of the same set
        lk_valid = 1; lk_hit = 1; lk_set = 7; lk_way = 3;
        @(negedge clk);
        mdl[7] = ref_update(mdl[7], 3);
        probe(7, "R7 back-to-back");
        // R9: just-hit way is not the victim
        do_hit(7, 1);
        probe(7, "R9 hit way not victim");
        check("R9 victim differs", int'(victim_way == 2'd1), 0);
        // R6: miss without miss_start
        lk_valid = 1; lk_hit = 0; lk_set = 5;
        @(negedge clk);
        idle_inputs();
        @(negedge clk);
        check("R6 miss no start", int'(victim_valid), 0);
        // R6: miss_start after a hit is ignored
        lk_valid = 1; lk_hit = 1; lk_set = 5; lk_way = 1;
        @(negedge clk);
        idle_inputs(); miss_start = 1;
        mdl[5] = ref_update(mdl[5], 1);
        @(negedge clk);
        miss_start = 0;
        check("R6 start after hit", int'(victim_valid), 0);
        // R6: stray miss_start with no lookup
        miss_start = 1;
        @(negedge clk);
        miss_start = 0;
        @(negedge clk);
        check("R6 stray start", int'(victim_valid), 0);
        probe(5, "R6 state after ignored start");

        // Random mix of hits and probes
        for (int i = 0; i < 400; i++) begin
            int s, w;
            s = $urandom_range(NUM_SETS - 1);
            w = $urandom_range(NUM_WAYS - 1);
            if ($urandom_range(2) != 0) begin
                do_hit(s, w);
                if ($urandom_range(1) != 0) begin
                    probe(s, "R9 random probe after hit");
                    check("R9 random differs", int'(int'(victim_way) == w), 0);
                end
            end else begin
                probe(s, "R8 random probe");
            end
        end

        // Second reset with lookups driven during the sweep: all sets clear
        do_reset(1'b1);
        for (int s = 0; s < NUM_SETS; s++) probe(s, "R1 cleared after reset");
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule